// File: doc/BRIEF.md
# Teletext PID Filter and Serializer

This block takes a byte-wide MPEG-2 transport stream, one byte per qualified clock, with a marker on the first byte of each 188-byte packet. Packets whose 13-bit packet identifier matches a programmed value are parsed further. Their adaptation fields are skipped and the PES header that starts a teletext unit is stripped. The remaining elementary-stream bytes are written into a byte FIFO.

The FIFO is drained as a serial bit stream, most significant bit first. The block has two output timings. In line mode, a bit clock of one quarter of the 27 MHz core clock (6.75 MHz) runs freely. A rising edge on the horizontal sync input restarts that clock's phase and arms a burst. The burst sends bytes back to back until the FIFO runs dry. In request mode, a phase accumulator produces bit slots at 37/144 of the core clock (6.9375 MHz). A bit advances only in a slot during which the external request input is high. The sync input has no effect in this mode.

Top module: `ttx_pid_serializer`

## Requirements
- R1: After synchronous reset, `ttx_dat` is 0, `ovf_flag` is 0 and the FIFO holds no bytes, so a later sync edge produces no output.
- R2: A packet is used only when its PID equals `cfg_pid` and its error bit is clear. The PID is bits [4:0] of byte 1 followed by all of byte 2. The error bit is bit 7 of byte 1. Any other packet adds nothing to the FIFO.
- R3: Bits [5:4] of byte 3 give the packet layout. When bit 5 is set, byte 4 is a length and that many further bytes are discarded. When bit 4 is clear, the packet carries no payload and adds nothing.
- R4: When bit 6 of byte 1 is set, the payload opens with a PES header. Its first three bytes must be 00 00 01. Header byte 8 (counting from 0) gives a count of further bytes to discard, and every byte after those is stored. A wrong start code stores nothing, and neither does any continuation packet until the next valid header.
- R5: In a matching packet with bit 6 of byte 1 clear, every payload byte is stored, provided a valid PES header has been seen since reset.
- R6: Bytes count only while `ts_valid` is high. A byte with `ts_start` high is byte 0 and must be 0x47. Bytes after byte 187 that arrive without a new start are ignored.
- R7: The FIFO holds `FIFO_DEPTH` bytes. A byte that arrives while it is full is dropped and sets `ovf_flag`. The flag stays set until reset.
- R8: In line mode (`cfg_req_mode`=0), a rising edge of `hsync` is first seen at some clock edge E0. The first byte's MSB appears on `ttx_dat` after edge E0+4. Each bit lasts 4 cycles and the bits go MSB first with no gap between bytes. `ttx_clk` is high in the first two cycles of each bit and low in the last two.
- R9: In line mode, a burst ends and `ttx_dat` returns to 0 at the first bit boundary where the FIFO is empty. Stored bytes are not sent until the next rising edge of `hsync`.
- R10: In request mode (`cfg_req_mode`=1), bits advance only in accumulator slots, exactly 37 in any 144 consecutive cycles, and only while `ttx_req` is high. `ttx_dat` holds its value while `ttx_req` is low, and `hsync` is ignored.
- R11: `ttx_dat` is 0 whenever no byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz core clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | Transport byte qualifier |
| ts_start | input | 1 | Marks byte 0 of a packet |
| ts_data | input | 8 | Transport stream byte |
| cfg_pid | input | 13 | PID to keep |
| cfg_req_mode | input | 1 | 0 = line mode, 1 = request mode |
| hsync | input | 1 | Horizontal sync, rising edge starts a burst |
| ttx_req | input | 1 | Bit request in request mode |
| ttx_clk | output | 1 | 6.75 MHz bit clock (line mode phase) |
| ttx_dat | output | 1 | Serial teletext data |
| ovf_flag | output | 1 | Sticky FIFO overflow |

## Verification
A parser that loses its place in a packet shows up on the first drained byte. The symptom is an extra, missing or shifted value within one burst, and a leftover byte makes a second sync edge produce ones. A wrong bit-slot phase or rate corrupts the very first serial bit after the sync edge. In request mode it changes the number of level changes counted over a 144-cycle window of alternating data. A FIFO count that drifts shows as a wrong overflow flag, or as lost or repeated bytes on the next drain.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    localparam logic [7:0] TS_SYNC     = 8'h47;
    localparam logic [7:0] TS_LAST_IDX = 8'd187;
    localparam logic [7:0] PES_LEN_IDX = 8'd8;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_HDR1,
        PS_HDR2,
        PS_HDR3,
        PS_AF_LEN,
        PS_AF_SKIP,
        PS_PES_HDR,
        PS_PES_SKIP,
        PS_PAYLOAD,
        PS_DROP
    } parse_state_e;

    typedef struct packed {
        logic       tei;
        logic       pusi;
        logic [4:0] pid_hi;
    } ts_flags_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } es_beat_t;

    typedef struct packed {
        logic       busy;
        logic       armed;
        logic [7:0] sh;
        logic [3:0] left;
    } ser_state_t;

    // State to enter once the packet header and adaptation field are consumed
    function automatic parse_state_e payload_entry(input logic pusi, input logic pes_open);
        if (pusi)
            return PS_PES_HDR;
        else if (pes_open)
            return PS_PAYLOAD;
        else
            return PS_DROP;
    endfunction

    // Expected byte of the PES start code prefix at index 0..2
    function automatic logic [7:0] start_code_byte(input logic [7:0] idx);
        return (idx == 8'd2) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/ttx_ts_parser.sv
module ttx_ts_parser
    import ttx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic [7:0]  in_data,
    input  logic [12:0] cfg_pid,
    output es_beat_t    es_out
);

    parse_state_e st, st_n;
    logic [7:0]   pos, pos_n;
    logic [7:0]   cnt, cnt_n;
    logic         pes_open, pes_open_n;
    ts_flags_t    fl, fl_n;
    logic         emit;

    always_comb begin
        st_n       = st;
        pos_n      = pos;
        cnt_n      = cnt;
        pes_open_n = pes_open;
        fl_n       = fl;
        emit       = 1'b0;
        if (in_valid) begin
            if (in_start) begin
                pos_n = 8'd1;
                st_n  = (in_data == TS_SYNC) ? PS_HDR1 : PS_IDLE;
            end else if (st != PS_IDLE) begin
                pos_n = pos + 8'd1;
                case (st)
                    PS_HDR1: begin
                        fl_n.tei    = in_data[7];
                        fl_n.pusi   = in_data[6];
                        fl_n.pid_hi = in_data[4:0];
                        st_n        = PS_HDR2;
                    end
                    PS_HDR2: begin
                        st_n = (!fl.tei && ({fl.pid_hi, in_data} == cfg_pid)) ? PS_HDR3 : PS_DROP;
                    end
                    PS_HDR3: begin
                        if (!in_data[4]) begin
                            st_n = PS_DROP;
                        end else if (in_data[5]) begin
                            st_n = PS_AF_LEN;
                        end else begin
                            st_n  = payload_entry(fl.pusi, pes_open);
                            cnt_n = 8'd0;
                        end
                    end
                    PS_AF_LEN: begin
                        if (in_data == 8'd0) begin
                            st_n  = payload_entry(fl.pusi, pes_open);
                            cnt_n = 8'd0;
                        end else begin
                            cnt_n = in_data;
                            st_n  = PS_AF_SKIP;
                        end
                    end
                    PS_AF_SKIP: begin
                        if (cnt == 8'd1) begin
                            st_n  = payload_entry(fl.pusi, pes_open);
                            cnt_n = 8'd0;
                        end else begin
                            cnt_n = cnt - 8'd1;
                        end
                    end
                    PS_PES_HDR: begin
                        if ((cnt < 8'd3) && (in_data != start_code_byte(cnt))) begin
                            pes_open_n = 1'b0;
                            st_n       = PS_DROP;
                        end else if (cnt == PES_LEN_IDX) begin
                            pes_open_n = 1'b1;
                            if (in_data == 8'd0) begin
                                st_n = PS_PAYLOAD;
                            end else begin
                                cnt_n = in_data;
                                st_n  = PS_PES_SKIP;
                            end
                        end else begin
                            cnt_n = cnt + 8'd1;
                        end
                    end
                    PS_PES_SKIP: begin
                        if (cnt == 8'd1)
                            st_n = PS_PAYLOAD;
                        else
                            cnt_n = cnt - 8'd1;
                    end
                    PS_PAYLOAD: emit = 1'b1;
                    default: ;
                endcase
                if (pos == TS_LAST_IDX) begin
                    st_n = PS_IDLE;
                    if ((st == PS_PES_HDR) && (cnt != PES_LEN_IDX))
                        pes_open_n = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_IDLE;
            pos      <= 8'd0;
            cnt      <= 8'd0;
            pes_open <= 1'b0;
            fl       <= '0;
            es_out   <= '0;
        end else begin
            st           <= st_n;
            pos          <= pos_n;
            cnt          <= cnt_n;
            pes_open     <= pes_open_n;
            fl           <= fl_n;
            es_out.valid <= emit;
            es_out.data  <= in_data;
        end
    end

endmodule

// File: rtl/ttx_byte_fifo.sv
module ttx_byte_fifo #(
    parameter int DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] dout,
    output logic       empty,
    output logic       full,
    output logic       ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_wr)
                wr_ptr <= ptr_inc(wr_ptr);
            if (do_rd)
                rd_ptr <= ptr_inc(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (push && full)
                ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/ttx_bit_timer.sv
module ttx_bit_timer #(
    parameter int DIV_RATIO = 4,
    parameter int ACC_INC   = 37,
    parameter int ACC_MOD   = 144
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_req,
    input  logic hs_rise,
    output logic tick,
    output logic bclk
);

    localparam int DW    = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int ACC_W = $clog2(ACC_MOD + ACC_INC);

    logic [DW-1:0]    div;
    logic [ACC_W-1:0] acc, acc_sum;
    logic             tick_line, tick_req;

    assign tick_line = (div == DW'(DIV_RATIO - 1));
    assign bclk      = (div < DW'(DIV_RATIO / 2));
    assign acc_sum   = acc + ACC_W'(ACC_INC);
    assign tick_req  = (acc_sum >= ACC_W'(ACC_MOD));
    assign tick      = mode_req ? tick_req : tick_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            div <= '0;
            acc <= '0;
        end else begin
            if (hs_rise && !mode_req)
                div <= '0;
            else if (tick_line)
                div <= '0;
            else
                div <= div + DW'(1);
            acc <= tick_req ? (acc_sum - ACC_W'(ACC_MOD)) : acc_sum;
        end
    end

endmodule

// File: rtl/ttx_serializer.sv
module ttx_serializer
    import ttx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_req,
    input  logic       tick,
    input  logic       req,
    input  logic       hs_rise,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_dout,
    output logic       pop,
    output logic       dat
);

    ser_state_t s, s_n;
    logic       gate, may_load, need_byte;

    assign gate      = mode_req ? (tick && req) : tick;
    assign may_load  = mode_req || s.armed;
    assign need_byte = !s.busy || (s.left == 4'd1);
    assign pop       = gate && need_byte && may_load && !fifo_empty;
    assign dat       = s.busy && s.sh[7];

    always_comb begin
        s_n = s;
        if (gate) begin
            if (!need_byte) begin
                s_n.sh   = {s.sh[6:0], 1'b0};
                s_n.left = s.left - 4'd1;
            end else if (may_load && !fifo_empty) begin
                s_n.sh   = fifo_dout;
                s_n.left = 4'd8;
                s_n.busy = 1'b1;
            end else begin
                s_n.busy  = 1'b0;
                s_n.left  = 4'd0;
                s_n.armed = 1'b0;
            end
        end
        if (!mode_req && hs_rise)
            s_n.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            s <= '0;
        else
            s <= s_n;
    end

endmodule

// File: rtl/ttx_pid_serializer.sv
module ttx_pid_serializer
    import ttx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2048,
    parameter int DIV_RATIO  = 4,
    parameter int ACC_INC    = 37,
    parameter int ACC_MOD    = 144
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ts_valid,
    input  logic        ts_start,
    input  logic [7:0]  ts_data,
    input  logic [12:0] cfg_pid,
    input  logic        cfg_req_mode,
    input  logic        hsync,
    input  logic        ttx_req,
    output logic        ttx_clk,
    output logic        ttx_dat,
    output logic        ovf_flag
);

    es_beat_t   es_beat;
    logic       fifo_pop, fifo_empty, fifo_full;
    logic [7:0] fifo_dout;
    logic       hs_q, hs_rise, bit_tick;

    assign hs_rise = hsync && !hs_q;

    always_ff @(posedge clk) begin
        if (rst)
            hs_q <= 1'b0;
        else
            hs_q <= hsync;
    end

    ttx_ts_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ts_valid),
        .in_start (ts_start),
        .in_data  (ts_data),
        .cfg_pid  (cfg_pid),
        .es_out   (es_beat)
    );

    ttx_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (es_beat.valid),
        .din   (es_beat.data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .ovf   (ovf_flag)
    );

    ttx_bit_timer #(
        .DIV_RATIO (DIV_RATIO),
        .ACC_INC   (ACC_INC),
        .ACC_MOD   (ACC_MOD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .mode_req (cfg_req_mode),
        .hs_rise  (hs_rise),
        .tick     (bit_tick),
        .bclk     (ttx_clk)
    );

    ttx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .mode_req   (cfg_req_mode),
        .tick       (bit_tick),
        .req        (ttx_req),
        .hs_rise    (hs_rise),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .pop        (fifo_pop),
        .dat        (ttx_dat)
    );

endmodule

// File: rtl/ttx_checker.sv
module ttx_checker (
    input logic clk,
    input logic rst,
    input logic mode_req,
    input logic req,
    input logic dat,
    input logic ovf,
    input logic tick,
    input logic pop,
    input logic empty,
    input logic full,
    input logic push
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);                                    // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);                         // R7

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                 // R11

    AST_DAT_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$stable(dat) |-> $past(tick));                  // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_req && !req) |=> $stable(dat));            // R10

    AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                 // R10

endmodule

bind ttx_pid_serializer ttx_checker u_ttx_checker (
    .clk      (clk),
    .rst      (rst),
    .mode_req (cfg_req_mode),
    .req      (ttx_req),
    .dat      (ttx_dat),
    .ovf      (ovf_flag),
    .tick     (bit_tick),
    .pop      (fifo_pop),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .push     (es_beat.valid)
);

// File: tb/ttx_pid_serializer_bench.sv
module ttx_pid_serializer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_valid = 1'b0;
    logic        ts_start = 1'b0;
    logic [7:0]  ts_data = 8'h00;
    logic [12:0] cfg_pid = 13'h0A5;
    logic        cfg_req_mode = 1'b0;
    logic        hsync = 1'b0;
    logic        ttx_req = 1'b0;
    logic        ttx_clk, ttx_dat, ovf_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    bit exp_open = 0;
    bit exp_ovf = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ttx_pid_serializer #(.FIFO_DEPTH(DEPTH)) u_ttx_pid_serializer (
        .clk          (clk),
        .rst          (rst),
        .ts_valid     (ts_valid),
        .ts_start     (ts_start),
        .ts_data      (ts_data),
        .cfg_pid      (cfg_pid),
        .cfg_req_mode (cfg_req_mode),
        .hsync        (hsync),
        .ttx_req      (ttx_req),
        .ttx_clk      (ttx_clk),
        .ttx_dat      (ttx_dat),
        .ovf_flag     (ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        exp_open = 0;
        exp_ovf  = 0;
    endtask

    // Builds and streams one packet; updates the expected FIFO contents.
    task automatic send_pkt(input logic [12:0] pid, input bit pusi, input bit tei,
                            input logic [1:0] afc, input int aflen, input int hlen,
                            input bit good_sc, input logic [7:0] seed, input logic [7:0] step);
        logic [7:0] pk [188];
        int pos0, es0;
        bit keep;
        pk[0] = 8'h47;
        pk[1] = {tei, pusi, 1'b0, pid[12:8]};
        pk[2] = pid[7:0];
        pk[3] = {2'b00, afc, 4'h0};
        pos0 = 4;
        if (afc[1]) begin
            pk[4] = 8'(aflen);
            for (int i = 0; i < aflen; i++) pk[5 + i] = 8'hFF;
            pos0 = 5 + aflen;
        end
        es0 = pos0;
        if (pusi && pos0 + 9 <= 188) begin
            pk[pos0 + 0] = 8'h00;
            pk[pos0 + 1] = 8'h00;
            pk[pos0 + 2] = good_sc ? 8'h01 : 8'h02;
            pk[pos0 + 3] = 8'hBD;
            pk[pos0 + 4] = 8'h00;
            pk[pos0 + 5] = 8'h00;
            pk[pos0 + 6] = 8'h80;
            pk[pos0 + 7] = 8'h00;
            pk[pos0 + 8] = 8'(hlen);
            for (int i = 0; i < hlen; i++) pk[pos0 + 9 + i] = 8'hFF;
            es0 = pos0 + 9 + hlen;
        end
        for (int i = es0; i < 188; i++) pk[i] = seed + 8'(i - es0) * step;
        keep = (pid == cfg_pid) && !tei && afc[0];
        if (keep) begin
            if (pusi) exp_open = good_sc;
            if (exp_open && (!pusi || good_sc)) begin
                for (int i = es0; i < 188; i++) begin
                    if (exp_q.size() < DEPTH) exp_q.push_back(pk[i]);
                    else exp_ovf = 1;
                end
            end
        end
        for (int i = 0; i < 188; i++) begin
            if (i % 50 == 25) begin
                @(negedge clk);
                ts_valid = 1'b0;
                ts_start = 1'b1;
                ts_data  = 8'h47;
            end
            @(negedge clk);
            ts_valid = 1'b1;
            ts_start = (i == 0);
            ts_data  = pk[i];
        end
        @(negedge clk);
        ts_valid = 1'b0;
        ts_start = 1'b0;
    endtask

    // Counts ones on ttx_dat over a number of cycles.
    task automatic watch_low(input int cycles, input string req);
        int ones = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ttx_dat) ones++;
        end
        chk(ones == 0, req, ones, 0);
    endtask

    // Line-mode drain: hsync edge, then sample each bit mid-slot.
    task automatic drain_line(input string req);
        int n = exp_q.size();
        @(negedge clk);
        hsync = 1'b1;
        repeat (5) @(posedge clk);
        for (int b = 0; b < n; b++) begin
            logic [7:0] got = 8'h00;
            logic [7:0] want;
            for (int k = 7; k >= 0; k--) begin
                @(negedge clk);
                got[k] = ttx_dat;
                if (b == 0 && k == 7) begin
                    chk(ttx_clk == 1'b1, "R8 clk high", int'(ttx_clk), 1);
                    repeat (2) @(posedge clk);
                    @(negedge clk);
                    chk(ttx_clk == 1'b0, "R8 clk low", int'(ttx_clk), 0);
                    repeat (2) @(posedge clk);
                end else begin
                    repeat (4) @(posedge clk);
                end
            end
            want = exp_q.pop_front();
            chk(got == want, req, int'(got), int'(want));
        end
        @(negedge clk);
        chk(ttx_dat == 1'b0, "R9 burst end", int'(ttx_dat), 0);
        hsync = 1'b0;
        repeat (3) @(negedge clk);
        hsync = 1'b1;
        watch_low(48, "R9 fifo drained");
        hsync = 1'b0;
    endtask

    task automatic count_edges(input int cycles, input int expect_n, input string req);
        int n = 0;
        logic prev = ttx_dat;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ttx_dat != prev) n++;
            prev = ttx_dat;
        end
        chk(n == expect_n, req, n, expect_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        chk(ttx_dat == 1'b0, "R1 dat", int'(ttx_dat), 0);
        chk(ovf_flag == 1'b0, "R1 ovf", int'(ovf_flag), 0);
        hsync = 1'b1;
        watch_low(40, "R1 empty");
        hsync = 1'b0;

        // Round A: one good unit, then PID, error, layout and framing rejects
        send_pkt(cfg_pid, 1, 0, 2'b11, 160, 0, 1, 8'h10, 8'h01);
        for (int b = 0; b < 13; b++)   // R2 sweep of every PID bit
            send_pkt(cfg_pid ^ (13'd1 << b), 1, 0, 2'b11, 160, 0, 1, 8'h80, 8'h01);
        send_pkt(cfg_pid, 0, 1, 2'b11, 170, 0, 1, 8'h90, 8'h01);   // R2 error bit
        send_pkt(cfg_pid, 0, 0, 2'b10, 183, 0, 1, 8'hA0, 8'h01);   // R3 no payload
        send_pkt(cfg_pid, 0, 0, 2'b00, 0, 0, 1, 8'hA8, 8'h01);     // R3 reserved
        for (int i = 0; i < 20; i++) begin                          // R6 strays
            @(negedge clk);
            ts_valid = 1'b1;
            ts_start = 1'b0;
            ts_data  = 8'h47;
        end
        @(negedge clk);
        ts_valid = 1'b0;
        chk(exp_q.size() == 14, "R2 model", exp_q.size(), 14);
        watch_low(60, "R9 wait for hsync");
        drain_line("R2 R3 R6 bytes");

        // Round B: sweep of PES header lengths with continuation packets
        for (int h = 1; h <= 4; h++) begin
            send_pkt(cfg_pid, 1, 0, 2'b11, 160, h, 1, 8'(h * 32), 8'h03);
            send_pkt(cfg_pid, 0, 0, 2'b11, 170, 0, 1, 8'(h * 7), 8'h05);  // R5
            drain_line("R4 R5 bytes");
        end

        // Round C: bad start code closes the unit, a good one reopens it
        send_pkt(cfg_pid, 1, 0, 2'b11, 160, 1, 0, 8'h33, 8'h01);
        send_pkt(cfg_pid, 0, 0, 2'b11, 170, 0, 1, 8'h44, 8'h01);
        chk(exp_q.size() == 0, "R4 model", exp_q.size(), 0);
        send_pkt(cfg_pid, 1, 0, 2'b11, 160, 2, 1, 8'h55, 8'h02);
        drain_line("R4 restart");

        // Round D: overflow and stickiness
        chk(ovf_flag == 1'b0, "R7 no ovf yet", int'(ovf_flag), 0);
        send_pkt(cfg_pid, 1, 0, 2'b11, 160, 0, 1, 8'h01, 8'h01);
        send_pkt(cfg_pid, 0, 0, 2'b11, 170, 0, 1, 8'h40, 8'h01);
        send_pkt(cfg_pid, 0, 0, 2'b11, 170, 0, 1, 8'h80, 8'h01);
        repeat (3) @(negedge clk);
        chk(ovf_flag == exp_ovf, "R7 ovf set", int'(ovf_flag), int'(exp_ovf));
        drain_line("R7 kept bytes");
        chk(ovf_flag == 1'b1, "R7 sticky", int'(ovf_flag), 1);

        // Request mode
        do_reset();
        @(negedge clk);
        chk(ovf_flag == 1'b0, "R7 reset clears", int'(ovf_flag), 0);
        cfg_req_mode = 1'b1;
        send_pkt(cfg_pid, 1, 0, 2'b11, 160, 0, 1, 8'hAA, 8'h00);  // 14 bytes 0xAA
        hsync = 1'b1;
        watch_low(40, "R10 hsync ignored");
        hsync = 1'b0;
        @(negedge clk);
        ttx_req = 1'b1;
        count_edges(144, 37, "R10 rate");
        ttx_req = 1'b0;
        count_edges(40, 0, "R10 hold");
        ttx_req = 1'b1;
        count_edges(432, 112 - 37, "R10 remaining bits");
        chk(ttx_dat == 1'b0, "R11 idle low", int'(ttx_dat), 0);
        ttx_req = 1'b0;
        exp_q.delete();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule